// File: doc/BRIEF.md
# Two-Wire Target Register Window

This block is a two-wire (I2C) target that lets a bus host read and write a flat byte map. The map starts with eight clock, calendar and control bytes and continues with a 56-byte general-purpose RAM, so it holds 64 bytes. One pointer covers the whole map. It moves forward by one after every data byte in either direction, and after the last byte it returns to the first. A transfer may carry any number of bytes.

The block runs on a system clock far faster than SCL, which is at most 400 kHz. It passes both bus lines through synchronizer stages and detects edges and bus conditions from the sampled levels. A host first sends the device address with the write direction, then sends the pointer byte and any data bytes. To read, the host sets the pointer with a write and then issues a repeated START followed by the address with the read direction. The block only ever pulls SDA low: `sda_oe` high means the data line is driven to zero.

Top module: `i2c_regmap_target`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new address phase from any state, including partway through a byte. A STOP (SDA rising while SCL is high) returns the block to idle. Neither one commits a partly received byte, and after either one SDA is released.
- R2: The first byte after a START holds the 7-bit device address 0x68 in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). On a match the block pulls SDA low for the ninth clock.
- R3: An address that does not match gets no acknowledge. The block leaves SDA released and ignores all following bytes, whether written or read, until the next START.
- R4: On a write, the first data byte loads the pointer. Each later byte is stored at the pointer, which then advances by one. Every byte is acknowledged.
- R5: A pointer byte of 0x40 or above loads the pointer with 0x00.
- R6: The pointer wraps from 0x3F to 0x00 on both writes and reads, so a transfer of any length keeps cycling through the map.
- R7: On a read, the block sends the byte at the pointer most significant bit first and advances the pointer after each byte. The next byte follows as long as the host acknowledges (SDA low on the ninth clock).
- R8: A host NACK (SDA high on the ninth clock of a read) ends the read. The pointer still advances past the byte just sent, and the block drives nothing until the next START or STOP.
- R9: A repeated START keeps the pointer, so a pointer set by a write followed by a repeated-START read returns data from that pointer.
- R10: The block changes SDA only after a falling edge of SCL (while SCL is low), or to release the line at a START or STOP.
- R11: After reset, SDA is released and all 64 map bytes read as 0x00. Addresses 0x00-0x07 hold the calendar and control bytes and 0x08-0x3F hold the RAM, and every byte can be both read and written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples both bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pin |
| sda_i | input | 1 | SDA level seen at the pin (wired-AND bus value) |
| sda_oe | output | 1 | High pulls SDA low; low releases the line |

## Verification
The checker watches four things on every cycle: SDA moves only in the cycle after a sampled SCL fall or a bus condition, START and STOP leave the line released, stores happen only on an SCL fall, and every store advances the pointer by exactly one with wrap. The bench scenarios are needed for everything that depends on content and ordering: the address match and its direction bit, the pointer loaded from the first written byte and clamped when out of range, wrap-around in both directions, a pointer that survives a repeated START, a NACK ending a read, and partial bytes discarded when a START or STOP cuts them off. A reference byte map in the bench, driven by constrained-random transfers, compares every byte read back.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

    localparam int BYTE_W   = 8;
    localparam int BIT_CW   = 4;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } cond_t;

    cond_t q, d;
    logic  scl_s, sda_s;

    assign scl_s = q.scl_sh[STAGES-1];
    assign sda_s = q.sda_sh[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_sh   = (q.scl_sh << 1) | STAGES'(scl_i);
        d.sda_sh   = (q.sda_sh << 1) | STAGES'(sda_i);
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scl_sh   <= '1;
            q.sda_sh   <= '1;
            q.scl_prev <= 1'b1;
            q.sda_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // Edges and bus conditions taken from the settled levels
    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int DEPTH = 64,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         DEPTH    = 64,
    parameter int         PTR_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_lvl,
    input  logic [7:0]       rdata,
    output logic             sda_oe,
    output logic             mem_we,
    output logic [7:0]       mem_wdata,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [BIT_CW-1:0] FULL_CNT = BIT_CW'(BYTE_W);

    typedef struct packed {
        tgt_state_e        st;
        logic [7:0]        sh;
        logic [BIT_CW-1:0] cnt;
        logic              rnw;
        logic              ptr_pending;
        logic              host_ack;
        logic [PTR_W-1:0]  ptr;
        logic              oe;
    } ctrl_t;

    ctrl_t q, d;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] load_ptr(input logic [7:0] b);
        return (32'(b) < DEPTH) ? PTR_W'(b) : '0;
    endfunction

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_wdata = q.sh;

        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL_CNT) begin
                        if (q.sh[7:1] == DEV_ADDR) begin
                            d.oe  = 1'b1;
                            d.rnw = q.sh[0];
                            d.st  = ST_ADDR_ACK;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rnw) begin
                            d.sh = rdata;
                            d.oe = ~rdata[7];
                            d.st = ST_RD_BYTE;
                        end else begin
                            d.oe          = 1'b0;
                            d.ptr_pending = 1'b1;
                            d.st          = ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL_CNT) begin
                        d.oe = 1'b1;
                        d.st = ST_WR_ACK;
                        if (q.ptr_pending) begin
                            d.ptr         = load_ptr(q.sh);
                            d.ptr_pending = 1'b0;
                        end else begin
                            mem_we = 1'b1;
                            d.ptr  = step_ptr(q.ptr);
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == FULL_CNT) begin
                            d.oe  = 1'b0;
                            d.ptr = step_ptr(q.ptr);
                            d.st  = ST_RD_ACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.host_ack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.host_ack) begin
                            d.sh  = rdata;
                            d.oe  = ~rdata[7];
                            d.cnt = '0;
                            d.st  = ST_RD_BYTE;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st          <= ST_IDLE;
            q.sh          <= '0;
            q.cnt         <= '0;
            q.rnw         <= 1'b0;
            q.ptr_pending <= 1'b0;
            q.host_ack    <= 1'b0;
            q.ptr         <= '0;
            q.oe          <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign ptr    = q.ptr;

endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         CAL_REGS    = 8,
    parameter int         RAM_BYTES   = 56,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int DEPTH = CAL_REGS + RAM_BYTES;
    localparam int PTR_W = $clog2(DEPTH);

    logic             sda_lvl;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             mem_we;
    logic [7:0]       mem_wdata;
    logic [7:0]       rdata;
    logic [PTR_W-1:0] ptr;

    i2c_line_cond #(
        .STAGES (SYNC_STAGES)
    ) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_ctrl #(
        .DEV_ADDR (DEV_ADDR),
        .DEPTH    (DEPTH),
        .PTR_W    (PTR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .rdata     (rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .ptr       (ptr)
    );

    i2c_reg_bank #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (mem_wdata),
        .rdata (rdata)
    );

endmodule

// File: rtl/i2c_regmap_target_chk.sv
module i2c_regmap_target_chk #(
    parameter int DEPTH = 64,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             scl_fall,
    input logic             start_det,
    input logic             stop_det,
    input logic             mem_we,
    input logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    // R10: line moves only after a sampled SCL fall or a bus condition
    assert_oe_on_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall | start_det | stop_det));

    // R1: STOP leaves the line released
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R1: START leaves the line released
    assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R4: a store happens only at an SCL fall
    assert_store_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> scl_fall);

    // R6: each store advances the pointer by one, wrapping at the top
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr == (($past(ptr) == LAST_IDX) ? '0 : $past(ptr) + 1'b1)));

endmodule

bind i2c_regmap_target i2c_regmap_target_chk #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mem_we    (mem_we),
    .ptr       (ptr)
);

// File: tb/sim_i2c_regmap_target.sv
`timescale 1ns/1ps
module sim_i2c_regmap_target;

    localparam int         Q     = 6;
    localparam int         DEPTH = 64;
    localparam logic [6:0] DEV   = 7'h68;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regmap_target u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;
    int         r10_bad = 0;
    logic [7:0] model [DEPTH];
    int         mptr;
    logic [7:0] wbuf [128];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int nxt(input int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    function automatic int ld(input logic [7:0] b);
        return (int'(b) < DEPTH) ? int'(b) : 0;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wq();
        scl_m = 1'b1; wq();
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = ~sda_line;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
            b = {b[6:0], sda_line};
            wq();
            scl_m = 1'b0; wq();
        end
        put_bit(~give_ack);
    endtask

    task automatic do_write(input logic [7:0] pb, input int n, input string tag);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); chk(a == 1'b1, "R2", a, 1);
        send_byte(pb, a);          chk(a == 1'b1, "R4", a, 1);
        mptr = ld(pb);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            chk(a == 1'b1, tag, a, 1);
            model[mptr] = wbuf[i];
            mptr = nxt(mptr);
        end
        bus_stop();
    endtask

    task automatic do_read(input bit set_ptr, input logic [7:0] pb, input int n, input string tag);
        logic a;
        logic [7:0] b;
        if (set_ptr) begin
            bus_start();
            send_byte({DEV, 1'b0}, a); chk(a == 1'b1, "R2", a, 1);
            send_byte(pb, a);          chk(a == 1'b1, "R4", a, 1);
            mptr = ld(pb);
        end
        bus_start();
        send_byte({DEV, 1'b1}, a); chk(a == 1'b1, "R2", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            chk(b == model[mptr], tag, b, model[mptr]);
            mptr = nxt(mptr);
        end
        bus_stop();
    endtask

    // R10 monitor: line must not move while SCL stays high
    logic scl_d = 1'b1;
    logic oe_d  = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n && scl_m && scl_d && (sda_oe != oe_d)) r10_bad++;
        scl_d = scl_m;
        oe_d  = sda_oe;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        mptr = 0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: reset state and zeroed map
        chk(sda_oe == 1'b0, "R11", sda_oe, 0);
        do_read(1'b1, 8'h00, 64, "R11");

        // R6 / R4: write across the top of the map and read it back
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        do_write(8'h3E, 3, "R4");
        chk(model[0] == 8'hC3, "R6", model[0], 8'hC3);
        do_read(1'b1, 8'h3E, 3, "R6");

        // R5: out-of-range pointer loads zero
        wbuf[0] = 8'hD4;
        do_write(8'h45, 1, "R5");
        do_read(1'b1, 8'h00, 1, "R5");
        wbuf[0] = 8'h5A;
        do_write(8'hFF, 1, "R5");
        do_read(1'b1, 8'h00, 1, "R5");

        // R7: read without setting pointer continues from current position
        do_read(1'b0, 8'h00, 3, "R7");

        // R3: wrong address, write and read
        bus_start();
        send_byte(8'hA0, a); chk(a == 1'b0, "R3", a, 0);
        send_byte(8'h05, a); chk(a == 1'b0, "R3", a, 0);
        send_byte(8'h77, a); chk(a == 1'b0, "R3", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD3, a); chk(a == 1'b0, "R3", a, 0);
        recv_byte(1'b0, b);  chk(b == 8'hFF, "R3", b, 8'hFF);
        bus_stop();
        do_read(1'b1, 8'h05, 1, "R3");

        // R8: NACK ends a read
        wbuf[0] = 8'h3C; wbuf[1] = 8'h81;
        do_write(8'h10, 2, "R4");
        bus_start();
        send_byte({DEV, 1'b0}, a); chk(a == 1'b1, "R2", a, 1);
        send_byte(8'h10, a);       chk(a == 1'b1, "R4", a, 1);
        bus_start();
        send_byte({DEV, 1'b1}, a); chk(a == 1'b1, "R9", a, 1);
        recv_byte(1'b1, b); chk(b == 8'h3C, "R9", b, 8'h3C);
        recv_byte(1'b0, b); chk(b == 8'h81, "R7", b, 8'h81);
        recv_byte(1'b0, b); chk(b == 8'hFF, "R8", b, 8'hFF);
        bus_stop();
        mptr = 8'h12;
        do_read(1'b0, 8'h00, 1, "R8");

        // R1: STOP in the middle of a data byte discards it
        bus_start();
        send_byte({DEV, 1'b0}, a); chk(a == 1'b1, "R2", a, 1);
        send_byte(8'h20, a);       chk(a == 1'b1, "R4", a, 1);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        do_read(1'b1, 8'h20, 1, "R1");

        // R1 / R9: repeated START in the middle of a byte keeps pointer
        wbuf[0] = 8'h9E;
        do_write(8'h21, 1, "R4");
        bus_start();
        send_byte({DEV, 1'b0}, a); chk(a == 1'b1, "R2", a, 1);
        send_byte(8'h21, a);       chk(a == 1'b1, "R4", a, 1);
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        bus_start();
        send_byte({DEV, 1'b1}, a); chk(a == 1'b1, "R1", a, 1);
        recv_byte(1'b0, b);        chk(b == 8'h9E, "R1", b, 8'h9E);
        bus_stop();
        mptr = 8'h22;

        // R6: transfer longer than the map, both directions
        for (int i = 0; i < 70; i++) wbuf[i] = 8'($urandom);
        do_write(8'h08, 70, "R6");
        do_read(1'b1, 8'h08, 70, "R6");

        // Constrained random transfers
        for (int t = 0; t < 40; t++) begin
            int op  = $urandom_range(0, 2);
            int len = $urandom_range(1, 6);
            logic [7:0] p = 8'($urandom_range(0, 79));
            if (op == 0) begin
                for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
                do_write(p, len, (p >= 8'h40) ? "R5" : "R4");
            end else if (op == 1) begin
                do_read(1'b1, p, len, "R9");
            end else begin
                do_read(1'b0, 8'h00, len, "R7");
            end
        end

        // R10: line never moved while SCL was high
        chk(r10_bad == 0, "R10", r10_bad, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule